// File: doc/BRIEF.md
# Streaming Corner-Turn Transposer

This block turns a stream of channelized samples from time-major order into channel-major order, so a downstream cross-multiply stage can consume each channel as one contiguous run. Words arrive one per handshake: for every time sample, all channels, and within each channel all signals, with the signal index changing fastest. The block collects one whole integration of `SAMPLES` time samples. It then emits the same words grouped by channel, then by signal, with the time index changing fastest.

Storage is split into two banks of `CHANNELS*SIGNALS*SAMPLES` words each. One bank fills while the other drains. Each bank has its own full flag. A bank becomes full when its last input word is written. It becomes empty when its last output word is accepted. Input is refused only when the bank next in line for writing still holds an undrained frame. Both sides use valid/ready handshakes. The output also carries a per-run last flag and a frame-end flag.

Top module: `ct_transposer`

## Requirements
- R1: During and right after a synchronous reset, both banks are empty: `out_valid` is 0 and `in_ready` is 1.
- R2: Input word k of a frame has indices t = k / (C*S), c = (k / S) mod C, s = k mod S. Output position j of a frame carries the input word with c = j / (S*T), s = (j / T) mod S, t = j mod T.
- R3: `out_last` is 1 exactly on output words whose time index is T-1, which marks the end of each (channel, signal) run.
- R4: `out_frame_end` is 1 exactly on the final output word of a frame (c = C-1, s = S-1, t = T-1). That word also has `out_last` set.
- R5: While one frame is held or drained, a complete next frame is accepted with `in_ready` high on every word. After a frame finishes draining, the next stored frame is presented on the very next cycle.
- R6: When both banks hold frames, `in_ready` is 0. It returns to 1 in the cycle after the final word of the draining frame is accepted.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_last` and `out_frame_end` hold their values.
- R8: `out_valid` stays 0 until all C*S*T words of a frame have been written.
- R9: Words presented with `in_valid` while `in_ready` is 0 are not stored. They change neither the frame being output nor the frame that is written next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | WORD_W | Input sample, 4-bit real and 4-bit imaginary by default |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | WORD_W | Reordered sample |
| out_last | output | 1 | Final time sample of a (channel, signal) run |
| out_frame_end | output | 1 | Final word of the frame |

## Verification
The embedded properties check the following on every cycle:
- the reset state;
- that output is held stable under backpressure;
- that a run continues without a gap after `out_last`;
- that the frame-end flag comes together with `out_last`;
- that input is released once a frame finishes draining;
- that both address generators stay in range.

The directed scenarios cover what only whole-frame traffic can show. They check the full three-axis ordering, word by word, across several frames. They show that a second frame is taken without stalls while the first is held. They show that words offered while input is refused never reach the output. They also show that reading and writing run at the same time under an irregular `out_ready` pattern.

// File: rtl/ct_pkg.sv
package ct_pkg;
   function automatic int ct_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/ct_wr_seq.sv
// Write-side address generator: steps through time, then channel, then signal
// (signal fastest) and scatters each word to its channel-major location.
module ct_wr_seq
   import ct_pkg::*;
#(
   parameter int CHANNELS = 4,
   parameter int SIGNALS  = 4,
   parameter int SAMPLES  = 8,
   parameter int ADDR_W   = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              frame_done
);
   localparam int CW    = ct_bits(CHANNELS);
   localparam int SW    = ct_bits(SIGNALS);
   localparam int TW    = ct_bits(SAMPLES);
   localparam int DEPTH = CHANNELS * SIGNALS * SAMPLES;

   logic [CW-1:0] ch_q;
   logic [SW-1:0] sg_q;
   logic [TW-1:0] tm_q;
   logic          sg_wrap, ch_wrap, tm_wrap;

   assign sg_wrap = (sg_q == SW'(SIGNALS - 1));
   assign ch_wrap = (ch_q == CW'(CHANNELS - 1));
   assign tm_wrap = (tm_q == TW'(SAMPLES - 1));

   always_comb begin
      addr = ADDR_W'((int'(ch_q) * SIGNALS + int'(sg_q)) * SAMPLES + int'(tm_q));
   end

   assign frame_done = step && sg_wrap && ch_wrap && tm_wrap;

   always_ff @(posedge clk) begin
      if (rst) begin
         ch_q <= '0;
         sg_q <= '0;
         tm_q <= '0;
      end else if (step) begin
         if (sg_wrap) begin
            sg_q <= '0;
            if (ch_wrap) begin
               ch_q <= '0;
               tm_q <= tm_wrap ? '0 : tm_q + 1'b1;
            end else begin
               ch_q <= ch_q + 1'b1;
            end
         end else begin
            sg_q <= sg_q + 1'b1;
         end
      end
   end

   // R2: scatter address always lands inside one bank
   a_r2_wr_addr_in_range: assert property (@(posedge clk) disable iff (rst)
      int'(addr) < DEPTH);
endmodule

// File: rtl/ct_rd_seq.sv
// Read-side sequencer: walks channel, then signal, then time (time fastest).
module ct_rd_seq
   import ct_pkg::*;
#(
   parameter int CHANNELS = 4,
   parameter int SIGNALS  = 4,
   parameter int SAMPLES  = 8,
   parameter int ADDR_W   = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              run_last,
   output logic              frame_last
);
   localparam int CW    = ct_bits(CHANNELS);
   localparam int SW    = ct_bits(SIGNALS);
   localparam int TW    = ct_bits(SAMPLES);
   localparam int DEPTH = CHANNELS * SIGNALS * SAMPLES;

   logic [CW-1:0] ch_q;
   logic [SW-1:0] sg_q;
   logic [TW-1:0] tm_q;
   logic          sg_wrap, ch_wrap;

   assign run_last   = (tm_q == TW'(SAMPLES - 1));
   assign sg_wrap    = (sg_q == SW'(SIGNALS - 1));
   assign ch_wrap    = (ch_q == CW'(CHANNELS - 1));
   assign frame_last = run_last && sg_wrap && ch_wrap;

   always_comb begin
      addr = ADDR_W'((int'(ch_q) * SIGNALS + int'(sg_q)) * SAMPLES + int'(tm_q));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ch_q <= '0;
         sg_q <= '0;
         tm_q <= '0;
      end else if (step) begin
         if (run_last) begin
            tm_q <= '0;
            if (sg_wrap) begin
               sg_q <= '0;
               ch_q <= ch_wrap ? '0 : ch_q + 1'b1;
            end else begin
               sg_q <= sg_q + 1'b1;
            end
         end else begin
            tm_q <= tm_q + 1'b1;
         end
      end
   end

   // R2: gather address always lands inside one bank
   a_r2_rd_addr_in_range: assert property (@(posedge clk) disable iff (rst)
      int'(addr) < DEPTH);
endmodule

// File: rtl/ct_bank_pair.sv
// Two identical storage banks; one written, one read, selected per port.
module ct_bank_pair #(
   parameter int WORD_W = 8,
   parameter int DEPTH  = 128,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              we,
   input  logic              wsel,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              rsel,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] bank_rd [2];

   for (genvar g = 0; g < 2; g++) begin : g_bank
      logic [WORD_W-1:0] store [DEPTH];
      always_ff @(posedge clk) begin
         if (we && (wsel == 1'(g))) begin
            store[waddr] <= wdata;
         end
      end
      assign bank_rd[g] = store[raddr];
   end

   assign rdata = rsel ? bank_rd[1] : bank_rd[0];
endmodule

// File: rtl/ct_transposer.sv
module ct_transposer
   import ct_pkg::*;
#(
   parameter int CHANNELS = 4,
   parameter int SIGNALS  = 4,
   parameter int SAMPLES  = 8,
   parameter int WORD_W   = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data,
   output logic              out_last,
   output logic              out_frame_end
);
   localparam int DEPTH  = CHANNELS * SIGNALS * SAMPLES;
   localparam int ADDR_W = ct_bits(DEPTH);

   if (CHANNELS < 1 || SIGNALS < 1 || SAMPLES < 2 || WORD_W < 2) begin : g_bad_cfg
      $error("ct_transposer: illegal geometry");
   end
   if (DEPTH > 4096) begin : g_too_deep
      $error("ct_transposer: bank depth too large");
   end

   logic [1:0]        full_q, full_d;
   logic              wr_bank_q, rd_bank_q;
   logic              wr_en, wr_done, rd_step, rd_done;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic              run_last, frame_last;

   assign in_ready = !full_q[wr_bank_q];
   assign wr_en    = in_valid && in_ready;
   assign out_valid = full_q[rd_bank_q];
   assign rd_step  = out_valid && out_ready;
   assign rd_done  = rd_step && frame_last;
   assign out_last = run_last;
   assign out_frame_end = frame_last;

   always_comb begin
      full_d = full_q;
      if (wr_en && wr_done) full_d[wr_bank_q] = 1'b1;
      if (rd_done)          full_d[rd_bank_q] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q    <= '0;
         wr_bank_q <= 1'b0;
         rd_bank_q <= 1'b0;
      end else begin
         full_q <= full_d;
         if (wr_en && wr_done) wr_bank_q <= !wr_bank_q;
         if (rd_done)          rd_bank_q <= !rd_bank_q;
      end
   end

   ct_wr_seq #(.CHANNELS(CHANNELS), .SIGNALS(SIGNALS), .SAMPLES(SAMPLES), .ADDR_W(ADDR_W)) u_wr (
      .clk(clk), .rst(rst), .step(wr_en), .addr(wr_addr), .frame_done(wr_done));

   ct_rd_seq #(.CHANNELS(CHANNELS), .SIGNALS(SIGNALS), .SAMPLES(SAMPLES), .ADDR_W(ADDR_W)) u_rd (
      .clk(clk), .rst(rst), .step(rd_step), .addr(rd_addr),
      .run_last(run_last), .frame_last(frame_last));

   ct_bank_pair #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
      .clk(clk), .we(wr_en), .wsel(wr_bank_q), .waddr(wr_addr), .wdata(in_data),
      .rsel(rd_bank_q), .raddr(rd_addr), .rdata(out_data));

   // R1: reset leaves both banks empty
   a_r1_reset_empty: assert property (@(posedge clk)
      rst |=> (!out_valid && in_ready));

   // R7: stalled output holds
   a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                     && $stable(out_last) && $stable(out_frame_end)));

   // R3: a run boundary inside a frame is followed by more words of the same bank
   a_r3_run_continues: assert property (@(posedge clk) disable iff (rst)
      (rd_step && out_last && !out_frame_end) |=> out_valid);

   // R4: frame end coincides with a run end
   a_r4_end_is_last: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_frame_end) |-> out_last);

   // R6: draining a frame frees input space next cycle
   a_r6_release_after_drain: assert property (@(posedge clk) disable iff (rst)
      (rd_step && out_frame_end) |=> in_ready);
endmodule

// File: tb/tb_ct_transposer.sv
module tb_ct_transposer;
   localparam int C = 4, S = 4, T = 8, W = 8;

   logic clk = 1'b0, rst = 1'b1;
   logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0, out_last, out_frame_end;
   logic [W-1:0] in_data = '0, out_data;
   int n_checks = 0, n_fail = 0, stall_cnt = 0;

   always #10 clk = !clk;

   ct_transposer #(.CHANNELS(C), .SIGNALS(S), .SAMPLES(T), .WORD_W(W)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last), .out_frame_end(out_frame_end));

   function automatic logic [W-1:0] wexp(int f, int c, int s, int t);
      return W'((t * 16 + c * 4 + s) ^ (f * 37));
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(20ns * 200000);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   // called just after a falling edge; returns just after the falling edge following acceptance
   task automatic push(input logic [W-1:0] w);
      in_data  = w;
      in_valid = 1'b1;
      forever begin
         if (in_ready) begin
            @(negedge clk);
            break;
         end
         stall_cnt++;
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic push_frame(input int f);
      for (int t = 0; t < T; t++)
         for (int c = 0; c < C; c++)
            for (int s = 0; s < S; s++)
               push(wexp(f, c, s, t));
   endtask

   // gap > 0 drops out_ready on every gap-th cycle
   task automatic drain_frame(input int f, input int gap);
      int cyc = 0;
      for (int c = 0; c < C; c++)
         for (int s = 0; s < S; s++)
            for (int t = 0; t < T; t++) begin
               forever begin
                  out_ready = (gap == 0) || ((cyc % gap) != 0);
                  cyc++;
                  if (out_ready && out_valid) begin
                     check(out_data == wexp(f, c, s, t), "R2 order", out_data, wexp(f, c, s, t));
                     check(out_last == (t == T - 1), "R3 last", out_last, (t == T - 1));
                     check(out_frame_end == (c == C-1 && s == S-1 && t == T-1), "R4 frame_end",
                           out_frame_end, (c == C-1 && s == S-1 && t == T-1));
                     @(negedge clk);
                     break;
                  end
                  @(negedge clk);
               end
            end
      out_ready = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
      check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
      rst = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
      check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
   endtask

   task automatic t_first_frame();
      int early = 0;
      for (int t = 0; t < T; t++)
         for (int c = 0; c < C; c++)
            for (int s = 0; s < S; s++) begin
               if (out_valid) early++;
               push(wexp(0, c, s, t));
            end
      check(early == 0, "R8 no output before full frame", early, 0);
      check(out_valid == 1'b1, "R8 output after full frame", out_valid, 1);
      check(out_data == wexp(0, 0, 0, 0), "R2 first word", out_data, wexp(0, 0, 0, 0));
   endtask

   task automatic t_hold();
      logic [W-1:0] d0 = out_data;
      logic         l0 = out_last;
      repeat (4) @(negedge clk);
      check(out_valid == 1'b1, "R7 valid held", out_valid, 1);
      check(out_data == d0, "R7 data held", out_data, d0);
      check(out_last == l0, "R7 last held", out_last, l0);
   endtask

   task automatic t_second_frame();
      stall_cnt = 0;
      push_frame(1);
      check(stall_cnt == 0, "R5 second frame without stall", stall_cnt, 0);
      check(in_ready == 1'b0, "R6 both banks full", in_ready, 0);
   endtask

   task automatic t_blocked_input();
      in_valid = 1'b1;
      in_data  = 8'hFF;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(in_ready == 1'b0, "R9 input refused", in_ready, 0);
      end
      in_valid = 1'b0;
      check(out_data == wexp(0, 0, 0, 0), "R9 output untouched", out_data, wexp(0, 0, 0, 0));
   endtask

   task automatic t_drain_first();
      drain_frame(0, 0);
      check(in_ready == 1'b1, "R6 input released after drain", in_ready, 1);
      check(out_valid == 1'b1, "R5 next frame presented at once", out_valid, 1);
      check(out_data == wexp(1, 0, 0, 0), "R5 next frame head", out_data, wexp(1, 0, 0, 0));
   endtask

   task automatic t_overlap();
      stall_cnt = 0;
      fork
         push_frame(2);
         drain_frame(1, 3);
      join
      check(stall_cnt == 0, "R5 write during read without stall", stall_cnt, 0);
      drain_frame(2, 0);
      check(out_valid == 1'b0, "R8 no output with banks empty", out_valid, 0);
      check(in_ready == 1'b1, "R6 input open with banks empty", in_ready, 1);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_first_frame();
      t_hold();
      t_second_frame();
      t_blocked_input();
      t_drain_first();
      t_overlap();
      finish_run();
   end
endmodule